// File: doc/BRIEF.md
# Multi-Bank Synchronous Clock Divider

This block takes one fast source clock and derives three banks of divided clocks (A, B and C, two identical outputs per bank) plus a fixed-ratio feedback clock. Each bank has its own ratio select. A global power-down input doubles every bank ratio. A 2-bit enable code chooses which banks toggle, and a disabled bank is parked low.

All outputs come from a single shared phase counter that wraps every 24 source cycles. 24 is the least common multiple of every ratio the block can produce, so the rising edges of all running outputs coincide at the start of each 24-cycle span. The selects, the power-down input and the enable code are sampled only at those span boundaries. Every output is low in the last cycle before a boundary, so a configuration change can never cut a pulse short.

An active-low asynchronous master reset clears the counter and every output and drops the output-enable flag, which tells the surrounding pad logic to tristate. After release the banks restart together.

Top module: `bank_clock_divider`

## Requirements
- R1: With power-down low, bank A divides the source clock by 2 when selA is 0 and by 4 when selA is 1. Both qA bits are always equal.
- R2: With power-down low, bank B divides by 2 when selB is 0 and by 4 when selB is 1. Both qB bits are always equal.
- R3: With power-down low, bank C divides by 4 when selC is 0 and by 6 when selC is 1. Every bank output is high for exactly the first half of its period, so a high phase of bank C is never shorter than 2 source cycles.
- R4: With power-down high, every bank ratio is doubled: A and B become 4 or 8, and C becomes 8 or 12.
- R5: qFb divides the source clock by 8 with a 4-high/4-low pattern. It ignores the selects, power-down and the enable code.
- R6: While rstN is low, all outputs and outEn are 0, asynchronously. On the first rising edge after release, outEn goes to 1 and every clock output is still 0.
- R7: The enable code clkEn selects the running banks: 2'b00 runs A only, 2'b01 runs A and B, 2'b10 runs A and C, and 2'b11 runs all three. A bank that is not running is held at 0.
- R8: On the second rising edge after reset release, and on every 24th edge after that, every running bank output and qFb rises together.
- R9: The selects, power-down and clkEn are sampled only on the first edge after release and on each edge that ends a 24-cycle span. A sampled value takes effect from the next edge. Changes at any other time have no effect until the next sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkSrc | input | 1 | Fast source clock |
| rstN | input | 1 | Asynchronous active-low master reset |
| selA | input | 1 | Bank A ratio select |
| selB | input | 1 | Bank B ratio select |
| selC | input | 1 | Bank C ratio select |
| pwrDn | input | 1 | Doubles every bank ratio when high |
| clkEn | input | 2 | Bank enable code |
| qA | output | 2 | Bank A clock outputs |
| qB | output | 2 | Bank B clock outputs |
| qC | output | 2 | Bank C clock outputs |
| qFb | output | 1 | Fixed divide-by-8 feedback clock |
| outEn | output | 1 | Output drive enable (0 means tristate) |

## Verification
Every clock output is registered: the value due after a rising edge is set by the phase and configuration that held before that edge, and the bench samples it at the following falling edge. outEn rises on the first edge after release, and the first high output appears one edge later. A configuration sampled at a span boundary shows on the outputs one edge after that boundary, so a change made mid-span is invisible for up to 24 cycles. The bench's model latches its copy of the inputs only at those same boundary edges, and the mid-span toggling phase checks that the earlier pattern continues until then.

// File: rtl/bank_clkdiv_pkg.sv
package bank_clkdiv_pkg;
  localparam int NBANK = 3;

  // Strobes and latched configuration handed from control to datapath
  typedef struct packed {
    logic             live;  // counter running since reset release
    logic [NBANK-1:0] run;   // per-bank run enable, bit0 = A
    logic [NBANK-1:0] sel;   // per-bank ratio select, bit0 = A
    logic             dbl;   // doubled ratios
  } ctlStrobe_t;
endpackage

// File: rtl/bank_clkdiv_ctrl.sv
module bank_clkdiv_ctrl
  import bank_clkdiv_pkg::*;
#(
  parameter int SPAN = 24,
  localparam int PW = $clog2(SPAN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NBANK-1:0] selIn,
  input  logic             dblIn,
  input  logic [1:0]       enCode,
  output ctlStrobe_t       ctl,
  output logic [PW-1:0]    phase
);
  localparam logic [PW-1:0] LAST = PW'(SPAN - 1);

  logic             live;
  logic [PW-1:0]    cnt;
  logic [NBANK-1:0] runQ;
  logic [NBANK-1:0] selQ;
  logic             dblQ;
  logic             loadCfg;

  // Code to running-bank mask: A always runs, code bit0 adds B, bit1 adds C
  function automatic logic [NBANK-1:0] decodeRun(input logic [1:0] code);
    return {code[1], code[0], 1'b1};
  endfunction

  // Configuration is taken only where every output is low
  assign loadCfg = !live || (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      live <= 1'b0;
      cnt  <= '0;
      runQ <= '0;
      selQ <= '0;
      dblQ <= 1'b0;
    end else begin
      if (loadCfg) begin
        runQ <= decodeRun(enCode);
        selQ <= selIn;
        dblQ <= dblIn;
      end
      if (!live) begin
        live <= 1'b1;
        cnt  <= '0;
      end else begin
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
    end
  end

  assign ctl   = '{live: live, run: runQ, sel: selQ, dbl: dblQ};
  assign phase = cnt;
endmodule

// File: rtl/bank_clkdiv_dp.sv
module bank_clkdiv_dp
  import bank_clkdiv_pkg::*;
#(
  parameter int SPAN   = 24,
  parameter int LO_A   = 2,
  parameter int HI_A   = 4,
  parameter int LO_B   = 2,
  parameter int HI_B   = 4,
  parameter int LO_C   = 4,
  parameter int HI_C   = 6,
  parameter int FB_DIV = 8,
  localparam int PW    = $clog2(SPAN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       ctl,
  input  logic [PW-1:0]    phase,
  output logic [NBANK-1:0] bankQ,
  output logic             fbQ
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int LO = (b == 0) ? LO_A : (b == 1) ? LO_B : LO_C;
    localparam int HI = (b == 0) ? HI_A : (b == 1) ? HI_B : HI_C;

    int   period;
    logic hiNow;
    logic qReg;

    // High for the first half of each period counted from phase 0
    always_comb begin
      period = ctl.sel[b] ? HI : LO;
      if (ctl.dbl) period = period * 2;
      hiNow = ctl.run[b] && ((int'(phase) % period) < (period / 2));
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) qReg <= 1'b0;
      else       qReg <= ctl.live && hiNow;
    end

    assign bankQ[b] = qReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fbQ <= 1'b0;
    else       fbQ <= ctl.live && ((int'(phase) % FB_DIV) < (FB_DIV / 2));
  end
endmodule

// File: rtl/bank_clock_divider.sv
module bank_clock_divider
  import bank_clkdiv_pkg::*;
#(
  parameter int SPAN   = 24,
  parameter int LO_A   = 2,
  parameter int HI_A   = 4,
  parameter int LO_B   = 2,
  parameter int HI_B   = 4,
  parameter int LO_C   = 4,
  parameter int HI_C   = 6,
  parameter int FB_DIV = 8,
  parameter int OUT_W  = 2
) (
  input  logic             clkSrc,
  input  logic             rstN,
  input  logic             selA,
  input  logic             selB,
  input  logic             selC,
  input  logic             pwrDn,
  input  logic [1:0]       clkEn,
  output logic [OUT_W-1:0] qA,
  output logic [OUT_W-1:0] qB,
  output logic [OUT_W-1:0] qC,
  output logic             qFb,
  output logic             outEn
);
  localparam int PW = $clog2(SPAN);

  ctlStrobe_t       ctl;
  logic [PW-1:0]    phase;
  logic [NBANK-1:0] bankQ;

  bank_clkdiv_ctrl #(.SPAN(SPAN)) u_ctrl (
    .clk    (clkSrc),
    .rstN   (rstN),
    .selIn  ({selC, selB, selA}),
    .dblIn  (pwrDn),
    .enCode (clkEn),
    .ctl    (ctl),
    .phase  (phase)
  );

  bank_clkdiv_dp #(
    .SPAN(SPAN), .LO_A(LO_A), .HI_A(HI_A), .LO_B(LO_B), .HI_B(HI_B),
    .LO_C(LO_C), .HI_C(HI_C), .FB_DIV(FB_DIV)
  ) u_dp (
    .clk   (clkSrc),
    .rstN  (rstN),
    .ctl   (ctl),
    .phase (phase),
    .bankQ (bankQ),
    .fbQ   (qFb)
  );

  assign qA    = {OUT_W{bankQ[0]}};
  assign qB    = {OUT_W{bankQ[1]}};
  assign qC    = {OUT_W{bankQ[2]}};
  assign outEn = ctl.live;
endmodule

// File: rtl/bank_clock_divider_chk.sv
module bank_clock_divider_chk #(
  parameter int SPAN  = 24,
  parameter int OUT_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       clkEn,
  input logic [OUT_W-1:0] qA,
  input logic [OUT_W-1:0] qB,
  input logic [OUT_W-1:0] qC,
  input logic             qFb,
  input logic             outEn
);
  localparam int LIMIT = 2 * SPAN + 2;
  localparam int QW    = $clog2(LIMIT + 1);

  logic          prevFb;
  logic [2:0]    fbHold;
  logic          fbSeen;
  logic          prevC;
  logic [3:0]    cRun;
  logic [QW-1:0] quietCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevFb   <= 1'b0;
      fbHold   <= '0;
      fbSeen   <= 1'b0;
      prevC    <= 1'b0;
      cRun     <= '0;
      quietCnt <= '0;
    end else begin
      prevFb <= qFb;
      if (qFb != prevFb) begin
        fbHold <= '0;
        fbSeen <= 1'b1;
      end else if (fbHold != 3'd7) begin
        fbHold <= fbHold + 3'd1;
      end
      prevC <= qC[0];
      if (!qC[0])             cRun <= '0;
      else if (cRun != 4'hF)  cRun <= cRun + 4'd1;
      if (clkEn != 2'b00)                 quietCnt <= '0;
      else if (quietCnt != QW'(LIMIT))    quietCnt <= quietCnt + 1'b1;
    end
  end

  AST_FB_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    (qFb != prevFb && fbSeen) |-> fbHold == 3'd3); // R5

  AST_OE_RISE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outEn) |-> (qA == '0 && qB == '0 && qC == '0 && !qFb)); // R6

  AST_C_NO_RUNT: assert property (@(posedge clk) disable iff (!rstN)
    (prevC && !qC[0]) |-> cRun >= 4'd2); // R3

  AST_EN_PARKS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (quietCnt == QW'(LIMIT)) |-> (qB == '0 && qC == '0)); // R7
endmodule

bind bank_clock_divider bank_clock_divider_chk #(.SPAN(SPAN), .OUT_W(OUT_W)) u_chk (
  .clk   (clkSrc),
  .rstN  (rstN),
  .clkEn (clkEn),
  .qA    (qA),
  .qB    (qB),
  .qC    (qC),
  .qFb   (qFb),
  .outEn (outEn)
);

// File: tb/bank_clock_divider_tb.sv
module bank_clock_divider_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN  = 1'b0;
  logic       selA  = 1'b0, selB = 1'b0, selC = 1'b0, pwrDn = 1'b0;
  logic [1:0] clkEn = 2'b11;
  logic [1:0] qA, qB, qC;
  logic       qFb, outEn;

  bank_clock_divider u_dut (
    .clkSrc(clk), .rstN(rstN), .selA(selA), .selB(selB), .selC(selC),
    .pwrDn(pwrDn), .clkEn(clkEn), .qA(qA), .qB(qB), .qC(qC),
    .qFb(qFb), .outEn(outEn)
  );

  int    nChk = 0, nFail = 0;
  bit    done = 0;
  string phaseTag = "";

  // Bench model state
  bit       mLive = 0;
  int       mPhase = 0;
  bit [2:0] mSel = 0, mRun = 0;
  bit       mDbl = 0;

  // R1..R4 ratio table
  function automatic int ratioOf(int b, bit s, bit d);
    int r;
    if (b == 2) r = s ? 6 : 4;
    else        r = s ? 4 : 2;
    return d ? 2 * r : r;
  endfunction

  // R7 code table
  function automatic bit [2:0] runOf(bit [1:0] code);
    case (code)
      2'b00:   return 3'b001;
      2'b01:   return 3'b011;
      2'b10:   return 3'b101;
      default: return 3'b111;
    endcase
  endfunction

  function automatic bit bankHigh(int b);
    int r = ratioOf(b, mSel[b], mDbl);
    return mLive && mRun[b] && ((mPhase % r) < (r / 2));
  endfunction

  task automatic check(string tag, int act, int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
  endtask

  function automatic string bankTag(string base, int b);
    return $sformatf("%s%s%s %s", base, mDbl ? " R4" : "",
                     (mLive && !mRun[b]) ? " R7" : "", phaseTag);
  endfunction

  // One source cycle: model the edge, then compare at the falling edge
  task automatic tick();
    bit [2:0] eb;
    bit       ef;
    @(posedge clk);
    eb = '0;
    ef = 1'b0;
    if (!rstN) begin
      mLive  = 0;
      mPhase = 0;
    end else begin
      for (int b = 0; b < 3; b++) eb[b] = bankHigh(b);
      ef = mLive && ((mPhase % 8) < 4);
      if (!mLive || mPhase == 23) begin
        mSel = {selC, selB, selA};
        mDbl = pwrDn;
        mRun = runOf(clkEn);
      end
      if (!mLive) begin
        mLive  = 1;
        mPhase = 0;
      end else begin
        mPhase = (mPhase == 23) ? 0 : mPhase + 1;
      end
    end
    @(negedge clk);
    check(bankTag("R1 qA", 0), qA, {2{eb[0]}});
    check(bankTag("R2 qB", 1), qB, {2{eb[1]}});
    check(bankTag("R3 qC", 2), qC, {2{eb[2]}});
    check({"R5 qFb ", phaseTag}, qFb, ef);
    check({"R6 outEn ", phaseTag}, outEn, rstN ? 1 : 0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed_1234);
    // Reset state
    phaseTag = "R6";
    repeat (3) tick();
    check("R6 reset outEn", outEn, 0);
    check("R6 reset qA", qA, 0);

    // Release and restart alignment
    @(negedge clk);
    rstN = 1'b1;
    phaseTag = "R8";
    tick();
    check("R6 first edge outEn", outEn, 1);
    check("R6 first edge qA", qA, 0);
    tick();
    check("R8 common rise", {qA, qB, qC, qFb}, 7'b1111111);
    repeat (46) tick();

    // Every ratio combination with all banks running
    phaseTag = "";
    for (int c = 0; c < 16; c++) begin
      {pwrDn, selC, selB, selA} = 4'(c);
      repeat (48) tick();
    end

    // Every enable code
    for (int e = 0; e < 4; e++) begin
      clkEn = 2'(e);
      {pwrDn, selC, selB, selA} = 4'($urandom_range(0, 15));
      repeat (48) tick();
    end
    clkEn = 2'b11;

    // Inputs toggling mid-span must wait for the boundary
    phaseTag = "R9";
    for (int i = 0; i < 120; i++) begin
      {pwrDn, selC, selB, selA} = 4'($urandom_range(0, 15));
      clkEn = 2'($urandom_range(0, 3));
      tick();
    end

    // Asynchronous reset seen before the next edge
    phaseTag = "R6";
    rstN = 1'b0;
    #1;
    check("R6 async qA", qA, 0);
    check("R6 async qC", qC, 0);
    check("R6 async outEn", outEn, 0);
    tick();
    @(negedge clk);
    rstN = 1'b1;
    phaseTag = "R8";
    tick();
    tick();
    check("R8 rise after mid-run reset qFb", qFb, 1);

    // Constrained random with occasional reset
    phaseTag = "";
    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(0, 9) == 0) {pwrDn, selC, selB, selA} = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 19) == 0) clkEn = 2'($urandom_range(0, 3));
      rstN = ($urandom_range(0, 249) != 0);
      tick();
    end

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule